// File: doc/BRIEF.md
# Dual-Comparator Relational Breakpoint Unit

This block watches every completed bus cycle of a processor with a 16-bit address bus. It holds two address comparators, A and B. Each comparator has a 4-bit cycle qualifier. The qualifier selects the address space (memory or I/O) and the direction (read, write or either). A 4-bit relation code then joins the two comparators in one of four ways: either comparator alone, A followed later by B, an address inside the inclusive span A..B, or an address outside that span. In the two span relations the qualifier of comparator A governs both ends.

A configuration port writes the two addresses, the two qualifiers and the relation. The unit flags a relational hit one clock after the bus cycle that caused it. It also flags, in the same way, any bus cycle during which the active-low external breakpoint input was low. While the unit is armed, a relational hit becomes a pending break. The pause request rises only once the processor reports the end of the current instruction. The request stays high until the unit is re-armed (resume) or disarmed.

The arming control is a four-state machine. ST_IDLE is disarmed. ST_ARMED waits for a hit. ST_PENDING holds a hit until the instruction ends. ST_PAUSED drives the pause request. The transitions are:
- ST_IDLE to ST_ARMED on arm_set.
- ST_ARMED to ST_PENDING on a hit in a cycle that does not end the instruction.
- ST_ARMED to ST_PAUSED on a hit in a cycle that does end the instruction.
- ST_PENDING to ST_PAUSED on instr_end.
- ST_PAUSED to ST_ARMED on arm_set.
- Any state to ST_IDLE on arm_clr.

The A-then-B sequence has its own two-state machine. SEQ_IDLE moves to SEQ_PRIMED on an A hit. SEQ_PRIMED moves back to SEQ_IDLE when B hits (this is the break), on arm_clr, or whenever the relation is not A-then-B.

Top module: `bkpt_unit`

## Requirements
- R1: After reset both addresses are 0000h, both qualifiers are 3 (memory read or write), the relation is C (either), and bp_hit, ext_hit, armed and pause_req are all 0.
- R2: A write with cfg_we=1 updates the register chosen by cfg_sel: 0 = address A, 1 = address B, 2 = qualifier A (cfg_wdata[3:0]), 3 = qualifier B (cfg_wdata[3:0]), 4 = relation (cfg_wdata[3:0]). cfg_sel values 5, 6 and 7 change nothing.
- R3: The qualifier codes match as follows (cyc_io=1 marks an I/O cycle, cyc_rd and cyc_wr give the direction): 1 = memory read, 2 = memory write, 3 = memory read or write, 5 = I/O read, 6 = I/O write, 7 = I/O read or write. Codes 0, 4 and 8 to 15 never match.
- R4: On I/O cycles only the low 8 bits of the bus address and of the stored addresses are compared. On memory cycles all 16 bits are compared.
- R5: Relation C (hex code C) hits when A matches, or B matches, or both, each under its own qualifier.
- R6: Relation D (A then B) works as follows. An A match primes the sequence. A later B match while primed is a hit and unprimes the sequence. A B match that coincides with the priming A match is not a hit. arm_clr, or any relation other than D, clears the primed state.
- R7: Relation E hits when the address lies in A..B inclusive and the cycle satisfies A's qualifier. B's qualifier is ignored. When A > B, nothing hits.
- R8: Relation F hits on a cycle that satisfies A's qualifier and whose address is below A, above B, or equal to A or B. When A > B, every qualified cycle hits.
- R9: A relation write whose code is not C, D, E or F leaves the relation unchanged.
- R10: bp_hit is 1 in the clock after a bus cycle (cyc_valid=1) that satisfies the relation, and 0 after a clock with cyc_valid=0.
- R11: A hit requests a pause only while the unit is armed. pause_req rises in the clock after the first instr_end at or after the hit. It stays 1 until arm_set, which resumes the armed state with pause_req=0.
- R12: arm_clr disarms the unit, drops pause_req and cancels a pending break. arm_clr wins over a simultaneous arm_set.
- R13: ext_hit is 1 in the clock after a bus cycle with ext_bp_n=0. It never requests a pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus cycle completes in this clock |
| cyc_addr | input | 16 | Bus cycle address |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_rd | input | 1 | Read cycle |
| cyc_wr | input | 1 | Write cycle |
| instr_end | input | 1 | Current instruction finishes in this clock |
| ext_bp_n | input | 1 | External breakpoint, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| arm_set | input | 1 | Arm, or resume from pause |
| arm_clr | input | 1 | Disarm |
| bp_hit | output | 1 | Relational hit for the previous bus cycle |
| ext_hit | output | 1 | External breakpoint seen in the previous bus cycle |
| armed | output | 1 | Break-stop is armed |
| pause_req | output | 1 | Pause request to the processor |

## Verification
The assertions take for granted that cyc_rd and cyc_wr are never both high in a valid bus cycle. They also assume that instr_end marks an instruction boundary, whether or not a bus cycle completes in that clock. The bench drives every bus cycle with exactly one direction bit. It raises instr_end only in dedicated clocks or in the cycle that carries the hit. Configuration writes are issued only in clocks without a bus cycle, so the comparators never see a register change in the same clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int QUAL_W = 4;
    localparam int REL_W  = 4;
    localparam int SEL_W  = 3;

    localparam logic [QUAL_W-1:0] QUAL_RESET = 4'h3;

    // relation codes C..F map onto the low two bits
    typedef enum logic [1:0] {
        REL_EITHER  = 2'd0,
        REL_SEQ     = 2'd1,
        REL_INSIDE  = 2'd2,
        REL_OUTSIDE = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2,
        ST_PAUSED  = 2'd3
    } arm_state_e;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_PRIMED = 1'b1
    } seq_state_e;

    localparam logic [SEL_W-1:0] SEL_ADDR_A = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR_B = 3'd1;
    localparam logic [SEL_W-1:0] SEL_QUAL_A = 3'd2;
    localparam logic [SEL_W-1:0] SEL_QUAL_B = 3'd3;
    localparam logic [SEL_W-1:0] SEL_REL    = 3'd4;

    typedef struct packed {
        logic en;
        logic io;
        logic wr;
        logic rd;
    } qual_t;

    function automatic qual_t decode_qual(input logic [QUAL_W-1:0] code);
        qual_t q;
        q.io = code[2];
        q.wr = code[1];
        q.rd = code[0];
        q.en = !code[3] && (code[1] || code[0]);
        return q;
    endfunction

    function automatic logic rel_code_ok(input logic [REL_W-1:0] code);
        return code[3:2] == 2'b11;
    endfunction

    function automatic rel_e rel_from_code(input logic [REL_W-1:0] code);
        return rel_e'(code[1:0]);
    endfunction

endpackage

// File: rtl/bkpt_cfg.sv
module bkpt_cfg
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   addr_a,
    output logic [ADDR_W-1:0]   addr_b,
    output logic [QUAL_W-1:0]   qual_a,
    output logic [QUAL_W-1:0]   qual_b,
    output rel_e                rel
);

    logic [QUAL_W-1:0] wr_code;
    assign wr_code = cfg_wdata[QUAL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_a <= '0;
            addr_b <= '0;
            qual_a <= QUAL_RESET;
            qual_b <= QUAL_RESET;
            rel    <= REL_EITHER;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_ADDR_A: addr_a <= cfg_wdata;
                SEL_ADDR_B: addr_b <= cfg_wdata;
                SEL_QUAL_A: qual_a <= wr_code;
                SEL_QUAL_B: qual_b <= wr_code;
                SEL_REL: begin
                    if (rel_code_ok(wr_code)) begin
                        rel <= rel_from_code(wr_code);
                    end
                end
                default: ;
            endcase
        end
    end

    AST_REL_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_REL && cfg_wdata[3:2] != 2'b11) |=> $stable(rel)); // R9

    AST_SPARE_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > SEL_REL) |=> ($stable(addr_a) && $stable(addr_b)
                                           && $stable(qual_a) && $stable(qual_b))); // R2

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input  logic [ADDR_W-1:0]  ref_addr,
    input  logic [QUAL_W-1:0]  qual,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_io,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic               cyc_ok,
    output logic               addr_lt,
    output logic               addr_gt
);

    localparam int HI_W = ADDR_W - PORT_W;

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] bus_m;
    logic [ADDR_W-1:0] ref_m;
    qual_t             q;

    assign keep_mask = bus_io ? {{HI_W{1'b0}}, {PORT_W{1'b1}}} : {ADDR_W{1'b1}};
    assign bus_m     = bus_addr & keep_mask;
    assign ref_m     = ref_addr & keep_mask;
    assign q         = decode_qual(qual);

    always_comb begin
        cyc_ok  = q.en && (q.io == bus_io) && ((q.rd && bus_rd) || (q.wr && bus_wr));
        addr_lt = bus_m < ref_m;
        addr_gt = bus_m > ref_m;
    end

endmodule

// File: rtl/bkpt_rel.sv
module bkpt_rel
    import bkpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_valid,
    input  logic        seq_clr,
    input  rel_e        rel,
    input  logic [1:0]  cyc_ok,
    input  logic [1:0]  addr_lt,
    input  logic [1:0]  addr_gt,
    output logic        rel_hit
);

    seq_state_e seq_q;
    seq_state_e seq_d;
    logic [1:0] addr_eq;
    logic [1:0] cmp_hit;
    logic       in_span;
    logic       out_span;
    logic       raw_hit;

    for (genvar i = 0; i < 2; i++) begin : g_side
        assign addr_eq[i] = !addr_lt[i] && !addr_gt[i];
        assign cmp_hit[i] = cyc_ok[i] && addr_eq[i];
    end

    assign in_span  = !addr_lt[0] && !addr_gt[1];
    assign out_span = addr_lt[0] || addr_gt[1] || addr_eq[0] || addr_eq[1];

    always_comb begin
        unique case (rel)
            REL_EITHER:  raw_hit = cmp_hit[0] || cmp_hit[1];
            REL_SEQ:     raw_hit = (seq_q == SEQ_PRIMED) && cmp_hit[1];
            REL_INSIDE:  raw_hit = cyc_ok[0] && in_span;
            REL_OUTSIDE: raw_hit = cyc_ok[0] && out_span;
        endcase
        rel_hit = cyc_valid && raw_hit;
    end

    always_comb begin
        seq_d = seq_q;
        if (seq_clr || rel != REL_SEQ) begin
            seq_d = SEQ_IDLE;
        end else if (cyc_valid) begin
            unique case (seq_q)
                SEQ_IDLE:   if (cmp_hit[0]) seq_d = SEQ_PRIMED;
                SEQ_PRIMED: if (cmp_hit[1]) seq_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

    AST_SEQ_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> (seq_q == SEQ_IDLE)); // R6

    AST_SEQ_NEEDS_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_hit && rel == REL_SEQ) |-> $past(seq_d == SEQ_PRIMED) || (seq_q == SEQ_PRIMED)); // R6

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_valid,
    input  logic [ADDR_W-1:0]  cyc_addr,
    input  logic               cyc_io,
    input  logic               cyc_rd,
    input  logic               cyc_wr,
    input  logic               instr_end,
    input  logic               ext_bp_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               arm_set,
    input  logic               arm_clr,
    output logic               bp_hit,
    output logic               ext_hit,
    output logic               armed,
    output logic               pause_req
);

    localparam int NCMP = 2;

    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    logic [QUAL_W-1:0] qual_a;
    logic [QUAL_W-1:0] qual_b;
    rel_e              rel;

    logic [ADDR_W-1:0] ref_addr [NCMP];
    logic [QUAL_W-1:0] ref_qual [NCMP];
    logic [NCMP-1:0]   cyc_ok;
    logic [NCMP-1:0]   addr_lt;
    logic [NCMP-1:0]   addr_gt;
    logic              rel_hit;

    arm_state_e        state_q;
    arm_state_e        state_d;

    bkpt_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .addr_a    (addr_a),
        .addr_b    (addr_b),
        .qual_a    (qual_a),
        .qual_b    (qual_b),
        .rel       (rel)
    );

    assign ref_addr[0] = addr_a;
    assign ref_addr[1] = addr_b;
    assign ref_qual[0] = qual_a;
    assign ref_qual[1] = qual_b;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        bkpt_cmp #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_cmp (
            .ref_addr (ref_addr[i]),
            .qual     (ref_qual[i]),
            .bus_addr (cyc_addr),
            .bus_io   (cyc_io),
            .bus_rd   (cyc_rd),
            .bus_wr   (cyc_wr),
            .cyc_ok   (cyc_ok[i]),
            .addr_lt  (addr_lt[i]),
            .addr_gt  (addr_gt[i])
        );
    end

    bkpt_rel u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .seq_clr   (arm_clr),
        .rel       (rel),
        .cyc_ok    (cyc_ok),
        .addr_lt   (addr_lt),
        .addr_gt   (addr_gt),
        .rel_hit   (rel_hit)
    );

    // per-cycle flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_hit  <= 1'b0;
            ext_hit <= 1'b0;
        end else begin
            bp_hit  <= rel_hit;
            ext_hit <= cyc_valid && !ext_bp_n;
        end
    end

    // arming state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm_set) state_d = ST_ARMED;
            ST_ARMED:   if (rel_hit) state_d = instr_end ? ST_PAUSED : ST_PENDING;
            ST_PENDING: if (instr_end) state_d = ST_PAUSED;
            ST_PAUSED:  if (arm_set) state_d = ST_ARMED;
        endcase
        if (arm_clr) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed     = state_q != ST_IDLE;
        pause_req = state_q == ST_PAUSED;
    end

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> !(cyc_rd && cyc_wr)); // R3

    AST_HIT_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> $past(cyc_valid)); // R10

    AST_PAUSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) |-> $past(instr_end)); // R11

    AST_DISARM_DROPS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr |=> (!pause_req && !armed)); // R12

    AST_EXT_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |-> $past(cyc_valid && !ext_bp_n)); // R13

endmodule

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        cyc_io = 1'b0;
    logic        cyc_rd = 1'b0;
    logic        cyc_wr = 1'b0;
    logic        instr_end = 1'b0;
    logic        ext_bp_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        arm_set = 1'b0;
    logic        arm_clr = 1'b0;
    logic        bp_hit;
    logic        ext_hit;
    logic        armed;
    logic        pause_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int  m_a = 0, m_b = 0, m_qa = 3, m_qb = 3, m_rel = 12;
    bit  m_seq = 0;

    always #5 clk = ~clk;

    bkpt_unit u_bkpt_unit (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_io(cyc_io), .cyc_rd(cyc_rd), .cyc_wr(cyc_wr), .instr_end(instr_end),
        .ext_bp_n(ext_bp_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .arm_set(arm_set), .arm_clr(arm_clr), .bp_hit(bp_hit), .ext_hit(ext_hit),
        .armed(armed), .pause_req(pause_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit q_ok(int q, bit io, bit rd, bit wr);
        case (q)
            1: return !io && rd;
            2: return !io && wr;
            3: return !io && (rd || wr);
            5: return io && rd;
            6: return io && wr;
            7: return io && (rd || wr);
            default: return 0;
        endcase
    endfunction

    function automatic int key(int v, bit io);
        return io ? (v % 256) : v;
    endfunction

    function automatic bit model_hit(int addr, bit io, bit rd, bit wr);
        int x = key(addr, io);
        int a = key(m_a, io);
        int b = key(m_b, io);
        bit ha = q_ok(m_qa, io, rd, wr) && x == a;
        bit hb = q_ok(m_qb, io, rd, wr) && x == b;
        case (m_rel)
            12: return ha || hb;
            13: return m_seq && hb;
            14: return q_ok(m_qa, io, rd, wr) && x >= a && x <= b;
            default: return q_ok(m_qa, io, rd, wr) && (x < a || x > b || x == a || x == b);
        endcase
    endfunction

    task automatic wr_cfg(input int sel, input int data);
        cfg_we = 1'b1; cfg_sel = sel[2:0]; cfg_wdata = data[15:0];
        @(posedge clk); #2;
        cfg_we = 1'b0;
        case (sel)
            0: m_a = data;
            1: m_b = data;
            2: m_qa = data % 16;
            3: m_qb = data % 16;
            4: if ((data % 16) >= 12) m_rel = data % 16;
            default: ;
        endcase
        if (m_rel != 13) m_seq = 0;
    endtask

    // one bus cycle, then check the hit flag against the model
    task automatic bus(input string req, input int addr, input bit io, input bit rd,
                       input bit wr, input bit iend, input bit extn);
        bit exp;
        exp = model_hit(addr, io, rd, wr);
        if (m_rel == 13) begin
            if (exp) m_seq = 0;
            else if (q_ok(m_qa, io, rd, wr) && key(addr, io) == key(m_a, io)) m_seq = 1;
        end
        cyc_valid = 1'b1; cyc_addr = addr[15:0]; cyc_io = io; cyc_rd = rd; cyc_wr = wr;
        instr_end = iend; ext_bp_n = extn;
        @(posedge clk); #2;
        cyc_valid = 1'b0; instr_end = 1'b0; ext_bp_n = 1'b1; cyc_rd = 1'b0; cyc_wr = 1'b0;
        chk(req, $sformatf("bp_hit addr=%h io=%0d rd=%0d wr=%0d", addr, io, rd, wr), bp_hit, exp);
    endtask

    task automatic idle(input bit iend);
        instr_end = iend;
        @(posedge clk); #2;
        instr_end = 1'b0;
    endtask

    task automatic arm(input bit s, input bit c);
        arm_set = s; arm_clr = c;
        @(posedge clk); #2;
        arm_set = 1'b0; arm_clr = 1'b0;
        if (c) m_seq = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1", "bp_hit reset", bp_hit, 0);
        chk("R1", "ext_hit reset", ext_hit, 0);
        chk("R1", "armed reset", armed, 0);
        chk("R1", "pause_req reset", pause_req, 0);
        // defaults: both compare 0000h, memory read/write, either relation
        bus("R1", 16'h0000, 0, 1, 0, 0, 1);
        bus("R1", 16'h0000, 0, 0, 1, 0, 1);
        bus("R1", 16'h0000, 1, 1, 0, 0, 1);
        bus("R1", 16'h0001, 0, 1, 0, 0, 1);

        // R10: matching address without a valid cycle
        cyc_addr = 16'h0000; cyc_rd = 1'b1;
        idle(0);
        cyc_rd = 1'b0;
        chk("R10", "bp_hit without cyc_valid", bp_hit, 0);

        // R3 / R4 qualifier sweep on comparator A, B disabled
        wr_cfg(3, 0);
        wr_cfg(0, 16'h5A3C);
        for (int q = 0; q < 16; q++) begin
            wr_cfg(2, q);
            for (int io = 0; io < 2; io++) begin
                for (int d = 0; d < 2; d++) begin
                    bus("R3", 16'h5A3C, io[0], d == 0, d == 1, 0, 1);
                    bus("R4", 16'hC33C, io[0], d == 0, d == 1, 0, 1);
                    bus("R3", 16'h5A3D, io[0], d == 0, d == 1, 0, 1);
                end
            end
        end
        // R5: comparator B alone under its own qualifier
        wr_cfg(2, 0);
        wr_cfg(1, 16'h0071);
        wr_cfg(3, 6);
        bus("R5", 16'h1271, 1, 0, 1, 0, 1);
        bus("R5", 16'h1271, 1, 1, 0, 0, 1);
        wr_cfg(2, 1);
        wr_cfg(0, 16'h0200);
        bus("R5", 16'h0200, 0, 1, 0, 0, 1);

        // R7 / R8 span sweeps, B qualifier set to something that would reject
        for (int pass = 0; pass < 4; pass++) begin
            bit io = pass[0];
            bit rev = pass[1];
            wr_cfg(0, rev ? 16'h0030 : 16'h0010);
            wr_cfg(1, 16'h0020);
            wr_cfg(2, io ? 7 : 1);
            wr_cfg(3, io ? 1 : 0);
            for (int r = 14; r < 16; r++) begin
                wr_cfg(4, r);
                for (int x = 16'h0C; x <= 16'h34; x++) begin
                    int ad = io ? (x + 16'hA500) : x;
                    bus(r == 14 ? "R7" : "R8", ad, io, 1, 0, 0, 1);
                    if (x % 4 == 0) bus(r == 14 ? "R7" : "R8", ad, io, 0, 1, 0, 1);
                end
            end
        end

        // R6 sequence
        wr_cfg(0, 16'h0100); wr_cfg(2, 1);
        wr_cfg(1, 16'h0048); wr_cfg(3, 6);
        wr_cfg(4, 13);
        bus("R6", 16'h0048, 1, 0, 1, 0, 1);
        bus("R6", 16'h0100, 0, 1, 0, 0, 1);
        bus("R6", 16'h0200, 0, 1, 0, 0, 1);
        bus("R6", 16'h0048, 1, 0, 1, 0, 1);
        chk("R6", "B after A hits", bp_hit, 1);
        bus("R6", 16'h0048, 1, 0, 1, 0, 1);
        chk("R6", "second B without A", bp_hit, 0);
        bus("R6", 16'h0100, 0, 1, 0, 0, 1);
        arm(0, 1);
        bus("R6", 16'h0048, 1, 0, 1, 0, 1);
        chk("R6", "B after disarm", bp_hit, 0);
        bus("R6", 16'h0100, 0, 1, 0, 0, 1);
        wr_cfg(4, 12);
        wr_cfg(4, 13);
        bus("R6", 16'h0048, 1, 0, 1, 0, 1);
        chk("R6", "B after relation change", bp_hit, 0);

        // R9 illegal relation codes ignored; R2 spare selects ignored
        wr_cfg(4, 12);
        wr_cfg(4, 5);
        wr_cfg(4, 16'h000B);
        bus("R9", 16'h0100, 0, 1, 0, 0, 1);
        chk("R9", "relation still either", bp_hit, 1);
        for (int s = 5; s < 8; s++) wr_cfg(s, 0);
        bus("R2", 16'h0100, 0, 1, 0, 0, 1);
        chk("R2", "spare select left A", bp_hit, 1);
        bus("R2", 16'h0048, 1, 0, 1, 0, 1);

        // R11 / R12 arming and pause
        wr_cfg(0, 16'h0050); wr_cfg(3, 0);
        bus("R11", 16'h0050, 0, 1, 0, 1, 1);
        chk("R11", "no pause disarmed", pause_req, 0);
        chk("R11", "armed stays 0", armed, 0);
        arm(1, 0);
        chk("R11", "armed after set", armed, 1);
        bus("R11", 16'h0050, 0, 1, 0, 0, 1);
        chk("R11", "pending, no pause yet", pause_req, 0);
        idle(0);
        chk("R11", "still pending", pause_req, 0);
        idle(1);
        chk("R11", "pause after instr_end", pause_req, 1);
        idle(0);
        chk("R11", "pause held", pause_req, 1);
        arm(1, 0);
        chk("R11", "resume drops pause", pause_req, 0);
        chk("R11", "resume keeps armed", armed, 1);
        bus("R11", 16'h0050, 0, 1, 0, 1, 1);
        chk("R11", "same-cycle end pauses", pause_req, 1);
        arm(0, 1);
        chk("R12", "disarm drops pause", pause_req, 0);
        chk("R12", "disarm clears armed", armed, 0);
        arm(1, 0);
        bus("R12", 16'h0050, 0, 1, 0, 0, 1);
        arm(0, 1);
        idle(1);
        chk("R12", "pending break cancelled", pause_req, 0);
        arm(1, 1);
        chk("R12", "clear beats set", armed, 0);

        // R13 external breakpoint
        arm(1, 0);
        bus("R13", 16'h0777, 0, 1, 0, 1, 0);
        chk("R13", "ext_hit flagged", ext_hit, 1);
        chk("R13", "ext does not pause", pause_req, 0);
        ext_bp_n = 1'b0;
        idle(1);
        ext_bp_n = 1'b1;
        chk("R13", "ext without cycle", ext_hit, 0);
        bus("R13", 16'h0777, 0, 1, 0, 0, 1);
        chk("R13", "ext_hit clear", ext_hit, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule